// File: doc/BRIEF.md
# Asynchronous Bus Cycle Sequencer

This block is the bus-master sequencer that turns a single core request into one or two word-wide transfers on an asynchronous, strobe-based external bus. The core presents a one-clock request pulse with a read/write flag, a word address, two byte enables, a long-word flag, an order flag and 32 bits of write data. The sequencer then walks the bus through a fixed series of phases: address released, address driven, address strobe and lane strobes asserted, and a sampling point where it waits for the slave's active-low transfer acknowledge (DTACK). It returns the read data and a one-clock completion pulse.

The block clock runs at twice the bus rate, so each clock is one half-cycle phase S0 to S7. DTACK passes through a configurable synchronizer. It is first sampled at the end of S5. Each failed sample adds a pair of wait phases before the next sample. A long-word request runs as two word cycles. By default the high word is taken at the base address and then the low word at the next word address. With the order flag set, the low word goes first, which is the order a stack push needs. Before any new address strobe, the sequencer waits until it has seen DTACK released after the previous strobe.

Top module: `asb_master`

## Requirements
- R1: While reset is held and after reset until a request arrives, bus_as_n, bus_uds_n, bus_lds_n and bus_rw_n are high, bus_addr_oe and bus_dout_oe are low, and rsp_done is low.
- R2: Each word cycle starts with one clock with the address bus released (S0), then one clock with the address driven (S1), then bus_as_n falls. bus_addr_oe stays high for as long as bus_as_n is low.
- R3: bus_dtack_n passes through SYNC_STAGES flip-flops. The synchronized acknowledge is sampled at the end of the fourth clock of the strobe (S5). While it is not seen, two wait clocks are added and it is sampled again. bus_as_n is therefore low for 5 + 2k clocks, where k is the number of failed samples.
- R4: bus_uds_n equals the inverse of req_be[1] (bus_din/bus_dout bits 15..8) and bus_lds_n the inverse of req_be[0] (bits 7..0) while bus_as_n is low. Long-word cycles assert both lane strobes. Lane strobes are high whenever bus_as_n is high.
- R5: Read data is captured from bus_din on the last clock edge of the strobe. For a word read, rsp_rdata[15:0] holds the enabled lanes, disabled lanes read as zero, and rsp_rdata[31:16] is zero.
- R6: In a write, bus_rw_n is low from S1 to S7, and bus_dout_oe is high from S3 through S7 with bus_dout constant throughout. In a read, bus_rw_n stays high.
- R7: In a long-word transfer, the word at req_addr carries bits 31..16 and the word at req_addr+1 carries bits 15..0. With req_low_first low, the req_addr cycle comes first. With req_low_first high, the req_addr+1 cycle comes first.
- R8: After a strobe ends, no new strobe begins until the acknowledge has been observed released.
- R9: rsp_done is high for exactly one clock per request, including long-word requests. It is raised only after the final acknowledge has been observed released.
- R10: A request pulse that arrives while a transfer is in progress is ignored. It starts no bus cycle and causes no completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one clock per bus phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-clock request pulse, taken only when idle |
| req_read | input | 1 | 1 = read, 0 = write |
| req_long | input | 1 | 1 = 32-bit transfer in two word cycles |
| req_low_first | input | 1 | For long transfers, run the low word cycle first |
| req_addr | input | AW | Word address of the transfer |
| req_be | input | 2 | Byte enables for word transfers, bit 1 = upper lane |
| req_wdata | input | 32 | Write data; word writes use bits 15..0 |
| rsp_rdata | output | 32 | Read data, valid from the completion pulse on |
| rsp_done | output | 1 | One-clock completion pulse |
| bus_addr | output | AW | Word address on the bus |
| bus_addr_oe | output | 1 | Address bus drive enable |
| bus_rw_n | output | 1 | Read (high) / write (low) |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper lane strobe, active low |
| bus_lds_n | output | 1 | Lower lane strobe, active low |
| bus_dout | output | 16 | Write data to the bus |
| bus_dout_oe | output | 1 | Data bus drive enable |
| bus_din | input | 16 | Read data from the bus |
| bus_dtack_n | input | 1 | Transfer acknowledge from the slave, active low |

## Verification
Two activities of the block can meet in one clock. First, the release wait after one strobe can run into the start of the next word of a long transfer. A slave model holds DTACK low for a random number of clocks after the strobe ends, and the bench flags any strobe that begins while its own DTACK is still low. Second, a new core request can arrive while the sequencer is busy. The bench injects a second request pulse during random transfers and judges it by the number of bus cycles the slave logs and the number of completion pulses seen. The acknowledge delay is also randomized, and the bench compares the strobe width against its own prediction of how many wait pairs the synchronizer forces.

// File: rtl/asb_pkg.sv
package asb_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned LANE_W = WORD_W / 2;
  localparam int unsigned LONG_W = 2 * WORD_W;

  // One state per half bus clock, plus idle and release wait.
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_S0,
    PH_S1,
    PH_S2,
    PH_S3,
    PH_S4,
    PH_S5,
    PH_W1,
    PH_W2,
    PH_S6,
    PH_S7,
    PH_REC
  } asb_ph_e;

  // Address strobe window: S2 up to and including S6.
  function automatic logic ph_strobe(asb_ph_e p);
    return p inside {PH_S2, PH_S3, PH_S4, PH_S5, PH_W1, PH_W2, PH_S6};
  endfunction

  // Address drive window: S1 up to and including S7.
  function automatic logic ph_addr(asb_ph_e p);
    return p inside {PH_S1, PH_S2, PH_S3, PH_S4, PH_S5, PH_W1, PH_W2,
                     PH_S6, PH_S7};
  endfunction

  // Write data drive window: S3 up to and including S7.
  function automatic logic ph_drive(asb_ph_e p);
    return p inside {PH_S3, PH_S4, PH_S5, PH_W1, PH_W2, PH_S6, PH_S7};
  endfunction

  // Phases at whose end the synchronized acknowledge is tested.
  function automatic logic ph_sample(asb_ph_e p);
    return p inside {PH_S5, PH_W2};
  endfunction

  // Which half of a long word the current cycle carries.
  function automatic logic half_is_high(logic lng, logic idx, logic lo_first);
    return lng & ~(idx ^ lo_first);
  endfunction

  function automatic logic [WORD_W-1:0] lane_mask(logic [1:0] be);
    return {{LANE_W{be[1]}}, {LANE_W{be[0]}}};
  endfunction

endpackage

// File: rtl/asb_sync.sv
module asb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dtack_n_i,
  output logic ack_o
);

  generate
    if (STAGES == 0) begin : g_direct
      assign ack_o = ~dtack_n_i;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_q <= '1;
        end else begin
          sh_q[0] <= dtack_n_i;
          for (int i = 1; i < STAGES; i++) begin
            sh_q[i] <= sh_q[i-1];
          end
        end
      end
      assign ack_o = ~sh_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/asb_phase_fsm.sv
module asb_phase_fsm
  import asb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_i,
  input  logic    ack_i,
  input  logic    more_i,
  output asb_ph_e ph_o,
  output logic    accept_o,
  output logic    sample_o,
  output logic    word_end_o,
  output logic    done_o
);

  asb_ph_e ph_q, ph_d;
  logic    rec_clear;

  assign accept_o   = req_i && (ph_q == PH_IDLE);
  assign sample_o   = ph_sample(ph_q);
  assign word_end_o = (ph_q == PH_S7);
  assign rec_clear  = (ph_q == PH_REC) && !ack_i;
  assign done_o     = rec_clear && !more_i;
  assign ph_o       = ph_q;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (accept_o) ph_d = PH_S0;
      PH_S0:   ph_d = PH_S1;
      PH_S1:   ph_d = PH_S2;
      PH_S2:   ph_d = PH_S3;
      PH_S3:   ph_d = PH_S4;
      PH_S4:   ph_d = PH_S5;
      PH_S5:   ph_d = ack_i ? PH_S6 : PH_W1;
      PH_W1:   ph_d = PH_W2;
      PH_W2:   ph_d = ack_i ? PH_S6 : PH_W1;
      PH_S6:   ph_d = PH_S7;
      PH_S7:   ph_d = PH_REC;
      PH_REC:  if (rec_clear) ph_d = more_i ? PH_S0 : PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

endmodule

// File: rtl/asb_lane_path.sv
module asb_lane_path
  import asb_pkg::*;
#(
  parameter int unsigned AW = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              req_read_i,
  input  logic              req_long_i,
  input  logic              req_low_first_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [1:0]        req_be_i,
  input  logic [LONG_W-1:0] req_wdata_i,
  input  asb_ph_e           ph_i,
  input  logic              word_end_i,
  input  logic [WORD_W-1:0] bus_din_i,
  output logic              more_o,
  output logic              rd_o,
  output logic [AW-1:0]     addr_o,
  output logic [1:0]        be_o,
  output logic [WORD_W-1:0] dout_o,
  output logic [LONG_W-1:0] rdata_o
);

  logic              rd_q, lng_q, lf_q;
  logic [AW-1:0]     base_q;
  logic [1:0]        be_q;
  logic [LONG_W-1:0] wd_q, rdata_q;
  logic [1:0]        left_q;
  logic              idx, is_high, capture;
  logic [WORD_W-1:0] din_masked;

  assign idx        = lng_q && (left_q == 2'd1);
  assign is_high    = half_is_high(lng_q, idx, lf_q);
  assign addr_o     = (lng_q && !is_high) ? base_q + AW'(1) : base_q;
  assign be_o       = lng_q ? 2'b11 : be_q;
  assign dout_o     = is_high ? wd_q[LONG_W-1:WORD_W] : wd_q[WORD_W-1:0];
  assign capture    = rd_q && (ph_i == PH_S6);
  assign din_masked = bus_din_i & lane_mask(be_o);
  assign more_o     = (left_q != 2'd0);
  assign rd_o       = rd_q;
  assign rdata_o    = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b1;
      lng_q  <= 1'b0;
      lf_q   <= 1'b0;
      base_q <= '0;
      be_q   <= '0;
      wd_q   <= '0;
      left_q <= '0;
    end else if (accept_i) begin
      rd_q   <= req_read_i;
      lng_q  <= req_long_i;
      lf_q   <= req_low_first_i;
      base_q <= req_addr_i;
      be_q   <= req_be_i;
      wd_q   <= req_wdata_i;
      left_q <= req_long_i ? 2'd2 : 2'd1;
    end else if (word_end_i) begin
      left_q <= left_q - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (accept_i) begin
      rdata_q <= '0;
    end else if (capture) begin
      if (is_high) rdata_q[LONG_W-1:WORD_W] <= din_masked;
      else         rdata_q[WORD_W-1:0]      <= din_masked;
    end
  end

endmodule

// File: rtl/asb_master.sv
module asb_master
  import asb_pkg::*;
#(
  parameter int unsigned AW          = 23,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_read,
  input  logic              req_long,
  input  logic              req_low_first,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_be,
  input  logic [LONG_W-1:0] req_wdata,
  output logic [LONG_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_addr_oe,
  output logic              bus_rw_n,
  output logic              bus_as_n,
  output logic              bus_uds_n,
  output logic              bus_lds_n,
  output logic [WORD_W-1:0] bus_dout,
  output logic              bus_dout_oe,
  input  logic [WORD_W-1:0] bus_din,
  input  logic              bus_dtack_n
);

  // Named internal events, also observed by the bound checker.
  logic    dtack_seen;
  logic    accept;
  logic    sample_pt;
  logic    word_end;
  logic    more_words;
  logic    cyc_read;
  logic    strobe_on;
  logic [1:0] lanes;
  asb_ph_e ph;

  asb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .dtack_n_i (bus_dtack_n),
    .ack_o     (dtack_seen)
  );

  asb_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req),
    .ack_i      (dtack_seen),
    .more_i     (more_words),
    .ph_o       (ph),
    .accept_o   (accept),
    .sample_o   (sample_pt),
    .word_end_o (word_end),
    .done_o     (rsp_done)
  );

  asb_lane_path #(.AW(AW)) u_lanes (
    .clk             (clk),
    .rst_n           (rst_n),
    .accept_i        (accept),
    .req_read_i      (req_read),
    .req_long_i      (req_long),
    .req_low_first_i (req_low_first),
    .req_addr_i      (req_addr),
    .req_be_i        (req_be),
    .req_wdata_i     (req_wdata),
    .ph_i            (ph),
    .word_end_i      (word_end),
    .bus_din_i       (bus_din),
    .more_o          (more_words),
    .rd_o            (cyc_read),
    .addr_o          (bus_addr),
    .be_o            (lanes),
    .dout_o          (bus_dout),
    .rdata_o         (rsp_rdata)
  );

  assign strobe_on   = ph_strobe(ph);
  assign bus_as_n    = ~strobe_on;
  assign bus_uds_n   = ~(strobe_on && lanes[1]);
  assign bus_lds_n   = ~(strobe_on && lanes[0]);
  assign bus_addr_oe = ph_addr(ph);
  assign bus_rw_n    = ~(!cyc_read && ph_addr(ph));
  assign bus_dout_oe = !cyc_read && ph_drive(ph);

endmodule

// File: rtl/asb_master_chk.sv
module asb_master_chk
  import asb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_as_n,
  input logic              bus_uds_n,
  input logic              bus_lds_n,
  input logic              bus_addr_oe,
  input logic              bus_rw_n,
  input logic              bus_dout_oe,
  input logic [WORD_W-1:0] bus_dout,
  input logic              rsp_done,
  input logic              dtack_seen,
  input logic              sample_pt
);

  logic [7:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               low_q <= '0;
    else if (bus_as_n)        low_q <= '0;
    else if (low_q != 8'hFF)  low_q <= low_q + 8'd1;
  end

  a_r2_addr_before_as: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_as_n) |-> $past(bus_addr_oe));

  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_as_n |-> bus_addr_oe);

  a_r3_odd_low_span: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as_n) |-> (low_q >= 8'd5 && low_q[0]));

  a_r3_wait_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_pt && !dtack_seen) |=> (!bus_as_n && !sample_pt) ##1 (!bus_as_n && sample_pt));

  a_r4_lanes_need_as: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as_n |-> (bus_uds_n && bus_lds_n));

  a_r6_dout_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dout_oe && $past(bus_dout_oe)) |-> $stable(bus_dout));

  a_r6_rw_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr_oe |-> bus_rw_n);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r9_done_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (bus_as_n && !bus_addr_oe && !dtack_seen));

endmodule

bind asb_master asb_master_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_as_n    (bus_as_n),
  .bus_uds_n   (bus_uds_n),
  .bus_lds_n   (bus_lds_n),
  .bus_addr_oe (bus_addr_oe),
  .bus_rw_n    (bus_rw_n),
  .bus_dout_oe (bus_dout_oe),
  .bus_dout    (bus_dout),
  .rsp_done    (rsp_done),
  .dtack_seen  (dtack_seen),
  .sample_pt   (sample_pt)
);

// File: tb/asb_master_bench.sv
module asb_master_bench;

  localparam int AW   = 23;
  localparam int SYNC = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req, req_read, req_long, req_low_first;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_be;
  logic [31:0]   req_wdata;
  logic [31:0]   rsp_rdata;
  logic          rsp_done;
  logic [AW-1:0] bus_addr;
  logic          bus_addr_oe, bus_rw_n, bus_as_n, bus_uds_n, bus_lds_n;
  logic [15:0]   bus_dout;
  logic          bus_dout_oe;
  logic [15:0]   bus_din;
  logic          bus_dtack_n;

  int n_chk = 0;
  int n_err = 0;

  // slave configuration and log
  int            cfg_d, cfg_r;
  int            lg_n;
  logic [AW-1:0] lg_addr [4];
  logic          lg_rw   [4];
  logic          lg_uds  [4];
  logic          lg_lds  [4];
  logic [15:0]   lg_wd   [4];
  logic          lg_wdok [4];
  int            lg_low  [4];

  asb_master #(.AW(AW), .SYNC_STAGES(SYNC)) u_asb_master (
    .clk(clk), .rst_n(rst_n), .req(req), .req_read(req_read),
    .req_long(req_long), .req_low_first(req_low_first),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .bus_addr(bus_addr),
    .bus_addr_oe(bus_addr_oe), .bus_rw_n(bus_rw_n), .bus_as_n(bus_as_n),
    .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n), .bus_dout(bus_dout),
    .bus_dout_oe(bus_dout_oe), .bus_din(bus_din), .bus_dtack_n(bus_dtack_n)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input logic [AW-1:0] a);
    return a[15:0] ^ {a[22:15], a[7:0]} ^ 16'h5A3C;
  endfunction

  // Strobe length: first passing sample is the first odd phase index
  // at or after both S5 and the synchronizer delay.
  function automatic int exp_low(input int d);
    int p;
    p = 2 + d + SYNC;
    if (p < 5) p = 5;
    if (p % 2 == 0) p = p + 1;
    return p;
  endfunction

  function automatic logic [15:0] mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  // Slave model
  initial begin
    bit            in_cyc = 0;
    bit            rel_pend = 0;
    bit            wd_seen = 0;
    int            cnt = 0, low = 0, rel = 0;
    logic [AW-1:0] c_addr = '0;
    logic          c_rw = 1'b1, c_u = 1'b1, c_l = 1'b1;
    logic [15:0]   c_wd = '0;
    bus_dtack_n = 1'b1;
    bus_din     = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        bus_dtack_n = 1'b1; in_cyc = 0; rel_pend = 0;
      end else if (!bus_as_n) begin
        if (!in_cyc) begin
          chk(bus_dtack_n === 1'b1, "R8 strobe began with acknowledge still low",
              64'(bus_dtack_n), 64'd1);
          chk(bus_addr_oe === 1'b1, "R2 address enabled at strobe",
              64'(bus_addr_oe), 64'd1);
          in_cyc = 1; cnt = 0; low = 0; wd_seen = 0;
          c_addr = bus_addr; c_rw = bus_rw_n; c_u = bus_uds_n; c_l = bus_lds_n;
          bus_din = pat(bus_addr);
        end else begin
          cnt++;
        end
        low++;
        if (cnt == cfg_d) bus_dtack_n = 1'b0;
        if (bus_dout_oe) begin
          if (wd_seen)
            chk(bus_dout === c_wd, "R6 write data held", 64'(bus_dout), 64'(c_wd));
          c_wd = bus_dout; wd_seen = 1;
        end
      end else if (in_cyc) begin
        if (lg_n < 4) begin
          lg_addr[lg_n] = c_addr; lg_rw[lg_n] = c_rw; lg_uds[lg_n] = c_u;
          lg_lds[lg_n] = c_l; lg_wd[lg_n] = c_wd; lg_wdok[lg_n] = wd_seen;
          lg_low[lg_n] = low;
        end
        lg_n++;
        in_cyc = 0; rel = 0;
        if (cfg_r == 0) bus_dtack_n = 1'b1;
        else rel_pend = 1;
      end else if (rel_pend) begin
        rel++;
        if (rel >= cfg_r) begin bus_dtack_n = 1'b1; rel_pend = 0; end
      end
    end
  end

  task automatic check_idle(input string when);
    chk(bus_as_n && bus_uds_n && bus_lds_n && bus_rw_n && !bus_addr_oe &&
        !bus_dout_oe && !rsp_done, {"R1 idle outputs ", when},
        {57'd0, bus_as_n, bus_uds_n, bus_lds_n, bus_rw_n, bus_addr_oe,
         bus_dout_oe, rsp_done}, 64'b1111000);
  endtask

  task automatic xfer(input bit rd, input bit lng, input bit lf,
                      input logic [AW-1:0] a, input logic [1:0] be,
                      input logic [31:0] wd, input int d, input int r,
                      input bit inj);
    bit          got = 0;
    int          extra = 0;
    int          nexp;
    logic [31:0] rexp, rgot;
    logic [AW-1:0] ea;
    logic [15:0] ewd;
    cfg_d = d; cfg_r = r; lg_n = 0;
    rgot = '0;
    @(negedge clk);
    req = 1; req_read = rd; req_long = lng; req_low_first = lf;
    req_addr = a; req_be = be; req_wdata = wd;
    @(negedge clk);
    req = 0;
    for (int t = 0; t < 400 && !got; t++) begin
      if (inj && t == 2) begin
        req = 1; req_read = ~rd; req_addr = a ^ 23'h55;
      end
      if (inj && t == 3) req = 0;
      @(negedge clk);
      if (rsp_done) begin
        got = 1; rgot = rsp_rdata;
        chk(bus_dtack_n === 1'b1, "R9 done after acknowledge release",
            64'(bus_dtack_n), 64'd1);
      end
    end
    req = 0;
    chk(got, "R9 completion pulse seen", 64'(got), 64'd1);
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      if (rsp_done) extra++;
    end
    chk(extra == 0, "R9/R10 no further completion pulse", 64'(extra), 64'd0);
    nexp = lng ? 2 : 1;
    chk(lg_n == nexp, "R10 bus cycle count", 64'(lg_n), 64'(nexp));
    if (rd) begin
      if (lng) rexp = {pat(a), pat(a + 23'd1)};
      else     rexp = {16'h0, pat(a) & mask(be)};
      chk(rgot === rexp, lng ? "R7 long read data" : "R5 word read data",
          64'(rgot), 64'(rexp));
    end
    for (int i = 0; i < nexp && i < lg_n; i++) begin
      if (lng) ea = ((i == 0) ^ lf) ? a : a + 23'd1;
      else     ea = a;
      chk(lg_addr[i] === ea, "R7 cycle address order", 64'(lg_addr[i]), 64'(ea));
      chk(lg_rw[i] === rd, "R6 direction", 64'(lg_rw[i]), 64'(rd));
      chk({lg_uds[i], lg_lds[i]} === (lng ? 2'b00 : ~be), "R4 lane strobes",
          64'({lg_uds[i], lg_lds[i]}), 64'(lng ? 2'b00 : ~be));
      chk(lg_low[i] == exp_low(d), "R3 strobe width with wait pairs",
          64'(lg_low[i]), 64'(exp_low(d)));
      if (!rd) begin
        ewd = (lng && ea == a) ? wd[31:16] : wd[15:0];
        chk(lg_wdok[i] && lg_wd[i] === ewd, "R6 write data",
            64'(lg_wd[i]), 64'(ewd));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 0; req = 0; req_read = 1; req_long = 0; req_low_first = 0;
    req_addr = '0; req_be = 2'b11; req_wdata = '0; cfg_d = 0; cfg_r = 0; lg_n = 0;
    repeat (4) @(negedge clk);
    check_idle("in reset");
    rst_n = 1;
    repeat (2) @(negedge clk);
    check_idle("after reset");

    xfer(1, 0, 0, 23'h000100, 2'b11, 32'h0, 0, 0, 0);  // fastest read
    xfer(1, 0, 0, 23'h012345, 2'b01, 32'h0, 5, 1, 0);  // upper lane off, waits
    xfer(1, 0, 0, 23'h7FFF00, 2'b10, 32'h0, 2, 0, 0);  // one wait pair
    xfer(0, 0, 0, 23'h000200, 2'b10, 32'hDEAD_BEEF, 7, 2, 0);
    xfer(1, 1, 0, 23'h003000, 2'b00, 32'h0, 1, 0, 0);  // long, high first
    xfer(1, 1, 1, 23'h7FFFFF, 2'b00, 32'h0, 3, 6, 0);  // long, low first, wrap
    xfer(0, 1, 1, 23'h040000, 2'b00, 32'h1234_5678, 0, 8, 0); // push order
    xfer(1, 0, 0, 23'h000333, 2'b11, 32'h0, 4, 3, 1);  // ignored request

    for (int n = 0; n < 60; n++) begin
      logic [1:0] be;
      case ($urandom % 3)
        0:       be = 2'b01;
        1:       be = 2'b10;
        default: be = 2'b11;
      endcase
      xfer(1'($urandom % 2), ($urandom % 3) == 0, 1'($urandom % 2),
           23'($urandom), be, $urandom, int'($urandom % 8), int'($urandom % 7),
           ($urandom % 5) == 0);
    end

    repeat (4) @(negedge clk);
    check_idle("at end");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule